// File: doc/BRIEF.md
# Adder with Reduced-Copy Concurrent Error Check

This block wraps an 8-bit adder with a concurrent error checker. The checker runs a second arithmetic copy on the same operands and compares its result with the main sum. A static mode input selects one of three checker copies.

- **Exact:** a complete exact copy. Every result bit is compared.
- **Upper bits:** a copy that produces only the most significant result bits. Only those bits are compared.
- **Lower-part-OR:** an approximate adder of that kind. Its result must fall within a fixed tolerance of the main sum.

The checker structure is set at design time and does not depend on the operand stream. It costs less than full duplication because low-weight mismatches are allowed.

An operand pair is presented with a valid strobe. One clock later the block presents three registered outputs: the 9-bit sum with carry, an error flag and an output strobe. A testbench can force a stuck value onto any one bit of the main adder's result. This shows which faults each checker copy catches and which it lets through.

Top module: `redup_adder_guard`

## Requirements
- R1: With fault injection disabled, one cycle after `in_valid` is high, `sum_q` equals `op_a + op_b` as a 9-bit value, with the carry in bit 8.
- R2: `out_valid` equals `in_valid` delayed by one cycle. While `rst` is high, `sum_q`, `err_q` and `out_valid` are held at zero.
- R3: With `mode_sel` = 2'b00 (exact copy), `err_q` is high exactly when any bit of the main result differs from the true sum.
- R4: With `mode_sel` = 2'b01 (upper copy, K = 4), `err_q` is high exactly when bits 8..5 of the main result differ from those of the true sum. A fault on bits 4..0 never raises `err_q`.
- R5: With `mode_sel` = 2'b10 (approximate copy, L = 4), the reference value is computed as follows:
  - its low 4 bits are `op_a[3:0] | op_b[3:0]`;
  - its bits 8..4 are `op_a[7:4] + op_b[7:4]`, with no carry from the low part.
  
  `err_q` is high exactly when the absolute difference between the main result and this reference exceeds 15.
- R6: With fault injection disabled, `err_q` stays low for every operand pair in every mode.
- R7: `mode_sel` = 2'b11 checks exactly like the exact copy.
- R8: When `in_valid` is low, the next cycle has `out_valid` and `err_q` low and `sum_q` unchanged.
- R9: When `flt_en` is high and `flt_bit` is 0..8, result bit `flt_bit` of the main adder is forced to `flt_val` before the register and before the comparison. A `flt_bit` value of 9 or above changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Checker copy select (00 exact, 01 upper bits, 10 approximate, 11 exact) |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| in_valid | input | 1 | Operand strobe |
| flt_en | input | 1 | Enable stuck-bit injection on the main result |
| flt_bit | input | 4 | Index of the main result bit to force |
| flt_val | input | 1 | Value forced onto the selected bit |
| sum_q | output | 9 | Registered main sum with carry |
| err_q | output | 1 | Registered checker mismatch flag |
| out_valid | output | 1 | Registered result strobe |

## Verification
The hardest case to reach from the ports is a fault that the approximate checker should tolerate. A stuck bit shifts the main result by a power of two. Whether the mismatch then exceeds the tolerance depends on where that shift falls relative to the AND of the operands' low nibbles, which is the approximate copy's own error. The bench therefore drives every stuck bit position and both stuck values over a grid of operand pairs, with both aligned and misaligned low nibbles, in every mode. It predicts each flag from the arithmetic definition of each checker copy. Operand sweeps without faults, run in all four mode codes, cover the claim that a fault-free adder never raises the flag.

// File: rtl/redup_pkg.sv
package redup_pkg;
  typedef enum logic [1:0] {
    CHK_EXACT  = 2'b00,
    CHK_UPPER  = 2'b01,
    CHK_APPROX = 2'b10,
    CHK_SPARE  = 2'b11
  } chk_mode_e;
endpackage

// File: rtl/rsum_add.sv
module rsum_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   s
);
  assign s = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/rsum_upper.sv
module rsum_upper #(
  parameter int W = 8,
  parameter int K = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [K-1:0] s_hi
);
  localparam int SH = W + 1 - K;
  logic [W-SH:0] hi_sum;
  logic          c_in;
  // carry into the kept field comes from the full low operands
  generate
    if (SH > 0) begin : g_low
      logic [SH:0] low_sum;
      assign low_sum = {1'b0, a[SH-1:0]} + {1'b0, b[SH-1:0]};
      assign c_in    = low_sum[SH];
      assign hi_sum  = {1'b0, a[W-1:SH]} + {1'b0, b[W-1:SH]} + {{(W-SH){1'b0}}, c_in};
    end else begin : g_all
      assign c_in   = 1'b0;
      assign hi_sum = {1'b0, a} + {1'b0, b};
    end
  endgenerate
  assign s_hi = hi_sum[K-1:0];
endmodule

// File: rtl/rsum_loa.sv
module rsum_loa #(
  parameter int W = 8,
  parameter int L = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   s
);
  logic [L-1:0] lo;
  logic [W-L:0] hi;
  for (genvar i = 0; i < L; i++) begin : g_or
    assign lo[i] = a[i] | b[i];
  end
  assign hi = {1'b0, a[W-1:L]} + {1'b0, b[W-1:L]};
  assign s  = {hi, lo};
endmodule

// File: rtl/rsum_fault.sv
module rsum_fault #(
  parameter int W  = 8,
  parameter int IW = 4
) (
  input  logic [W:0]    s_in,
  input  logic          en,
  input  logic [IW-1:0] idx,
  input  logic          val,
  output logic [W:0]    s_out
);
  for (genvar i = 0; i <= W; i++) begin : g_bit
    assign s_out[i] = (en && idx == IW'(i)) ? val : s_in[i];
  end
endmodule

// File: rtl/rsum_cmp.sv
module rsum_cmp
  import redup_pkg::*;
#(
  parameter int W   = 8,
  parameter int K   = 4,
  parameter int TOL = 15
) (
  input  chk_mode_e    mode,
  input  logic [W:0]   main_s,
  input  logic [W:0]   dup_s,
  input  logic [K-1:0] upper_s,
  input  logic [W:0]   loa_s,
  output logic         err
);
  localparam int SH = W + 1 - K;
  logic [W:0] diff;
  assign diff = (main_s >= loa_s) ? (main_s - loa_s) : (loa_s - main_s);
  always_comb begin
    unique case (mode)
      CHK_UPPER:  err = (main_s[W:SH] != upper_s);
      CHK_APPROX: err = (diff > (W+1)'(TOL));
      default:    err = (main_s != dup_s);
    endcase
  end
endmodule

// File: rtl/redup_adder_guard.sv
module redup_adder_guard
  import redup_pkg::*;
#(
  parameter int W   = 8,
  parameter int K   = 4,
  parameter int L   = 4,
  parameter int TOL = (1 << L) - 1,
  parameter int IW  = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          in_valid,
  input  logic          flt_en,
  input  logic [IW-1:0] flt_bit,
  input  logic          flt_val,
  output logic [W:0]    sum_q,
  output logic          err_q,
  output logic          out_valid
);
  localparam int SH = W + 1 - K;

  logic [W:0]   main_raw, main_f, dup_s, loa_s;
  logic [K-1:0] upper_s;
  logic         err_c;
  chk_mode_e    mode;

  assign mode = chk_mode_e'(mode_sel);

  rsum_add   #(.W(W))          u_main  (.a(op_a), .b(op_b), .s(main_raw));
  rsum_fault #(.W(W), .IW(IW)) u_flt   (.s_in(main_raw), .en(flt_en), .idx(flt_bit),
                                        .val(flt_val), .s_out(main_f));
  rsum_add   #(.W(W))          u_dup   (.a(op_a), .b(op_b), .s(dup_s));
  rsum_upper #(.W(W), .K(K))   u_upper (.a(op_a), .b(op_b), .s_hi(upper_s));
  rsum_loa   #(.W(W), .L(L))   u_loa   (.a(op_a), .b(op_b), .s(loa_s));
  rsum_cmp   #(.W(W), .K(K), .TOL(TOL)) u_cmp (
    .mode(mode), .main_s(main_f), .dup_s(dup_s), .upper_s(upper_s),
    .loa_s(loa_s), .err(err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      err_q     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      err_q     <= in_valid & err_c;
      if (in_valid) sum_q <= main_f;
    end
  end

  // R2: strobe latency
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8: flag only with a result; idle cycles keep the sum
  p_err_gated_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sum_q));
  // R1: clean sum
  p_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flt_en) |=> sum_q == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)}));
  // R6: no false alarm without a fault
  p_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flt_en) |=> !err_q);
  // R4: low-bit faults are tolerated by the upper copy
  p_low_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flt_en && mode_sel == 2'b01 && flt_bit < IW'(SH)) |=> !err_q);
endmodule

// File: tb/redup_adder_guard_test.sv
`timescale 1ns/1ps
module redup_adder_guard_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] mode_sel;
  logic [7:0] op_a, op_b;
  logic       in_valid, flt_en, flt_val;
  logic [3:0] flt_bit;
  logic [8:0] sum_q;
  logic       err_q, out_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  redup_adder_guard uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .op_a(op_a), .op_b(op_b),
    .in_valid(in_valid), .flt_en(flt_en), .flt_bit(flt_bit), .flt_val(flt_val),
    .sum_q(sum_q), .err_q(err_q), .out_valid(out_valid)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(string req, int a, int b, int md, bit fe, int fb, bit fv);
    int truth, mainv, loa, d;
    bit eexp;
    mode_sel = 2'(md); op_a = 8'(a); op_b = 8'(b);
    flt_en = fe; flt_bit = 4'(fb); flt_val = fv; in_valid = 1'b1;
    @(posedge clk); #1;
    truth = a + b;
    mainv = truth;
    if (fe && fb <= 8) mainv = fv ? (truth | (1 << fb)) : (truth & ~(1 << fb));
    loa = (((a >> 4) + (b >> 4)) << 4) | ((a | b) & 15);
    d = (mainv > loa) ? mainv - loa : loa - mainv;
    case (md)
      1: eexp = ((mainv >> 5) != (truth >> 5));
      2: eexp = (d > 15);
      default: eexp = (mainv != truth);
    endcase
    check({req, " sum"}, int'(sum_q), mainv);
    check({req, " err"}, int'(err_q), int'(eexp));
    check({req, " valid"}, int'(out_valid), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; mode_sel = 2'b00; op_a = 8'hFF; op_b = 8'hFF;
    flt_en = 1'b0; flt_bit = 4'd0; flt_val = 1'b0;
    repeat (3) @(posedge clk); #1;
    // R2: reset state
    check("R2 reset sum", int'(sum_q), 0);
    check("R2 reset err", int'(err_q), 0);
    check("R2 reset valid", int'(out_valid), 0);
    rst = 1'b0;

    // R1 R6 R7: clean sweeps in every mode code, plus corners
    for (int md = 0; md < 4; md++) begin
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 7)
          run_vec(md == 3 ? "R7 clean" : "R1 R6 clean", a, b, md, 1'b0, 0, 1'b0);
      run_vec("R1 corner", 255, 255, md, 1'b0, 0, 1'b0);
      run_vec("R6 corner", 15, 15, md, 1'b0, 0, 1'b0);
      run_vec("R1 zero", 0, 0, md, 1'b0, 0, 1'b0);
    end

    // R3 R4 R5 R7 R9: stuck bits on every position, both values
    for (int md = 0; md < 4; md++)
      for (int fb = 0; fb < 9; fb++)
        for (int fv = 0; fv < 2; fv++)
          for (int a = 0; a < 256; a += 17)
            for (int b = 3; b < 256; b += 13)
              run_vec(md == 0 ? "R3 R9 fault" : md == 1 ? "R4 R9 fault" :
                      md == 2 ? "R5 R9 fault" : "R7 fault",
                      a, b, md, 1'b1, fb, fv[0]);

    // R9: out-of-range index has no effect
    for (int md = 0; md < 3; md++)
      for (int a = 0; a < 256; a += 31)
        run_vec("R9 idx12", a, 255 - a, md, 1'b1, 12, 1'b1);

    // R8: idle cycle holds sum, drops strobe and flag
    run_vec("R8 setup", 200, 100, 0, 1'b1, 8, 1'b0);
    in_valid = 1'b0; op_a = 8'd1; op_b = 8'd2; flt_en = 1'b0;
    @(posedge clk); #1;
    check("R8 hold sum", int'(sum_q), 44);
    check("R8 idle err", int'(err_q), 0);
    check("R8 idle valid", int'(out_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule